// File: doc/BRIEF.md
# Supply-Fail Sequencer for Battery-Backed Memory

This controller supervises a static memory that keeps its contents on a backup cell when the main supply fails. Three comparator flags report where the supply stands. The highest flag marks the full-operation level. The middle flag marks the level at which writes must already be blocked. The lowest flag marks the level at which the memory has to be fed from the cell. The controller turns these flags into five outputs: a protect signal that makes the memory ignore its control and data inputs, an enable for the data output drivers, a select that chooses the backup source, a sticky enable that breaks the shipping seal on the cell, and a pull-down request for an open-drain host reset line.

Each flag passes through a two-stage synchronizer. A four-state machine then acts on the synchronized flags. The states are `ST_NORMAL`, `ST_PROTECT`, `ST_BATTERY` and `ST_HOLD`. Six transitions are defined:
- `ST_NORMAL → ST_PROTECT` when the middle flag drops.
- `ST_PROTECT → ST_BATTERY` when the lowest flag drops.
- `ST_BATTERY → ST_PROTECT` when the lowest flag returns.
- `ST_PROTECT → ST_HOLD` when the top flag returns.
- `ST_HOLD → ST_NORMAL` after `HOLD_CYCLES` clocks.
- `ST_HOLD → ST_PROTECT` (abort) when the top flag drops during the count.

Protection starts at the middle level but is released only after the top level is regained and the hold count has finished. This gives the protect signal its hysteresis. A full fail-and-recover cycle runs through normal, protect, battery, protect, hold and back to normal.

Top module: `pwr_seq_top`

## Requirements
- R1: While `rst_n` is low: `wr_prot_o`=1, `out_en_o`=0, `src_batt_o`=0, `batt_armed_o`=0, `rst_pull_o`=1. The machine leaves reset in `ST_PROTECT`, and every synchronizer stage reads 0.
- R2: A flag change driven between clock edges reaches `rst_pull_o` after the second rising edge. It reaches the state-derived outputs after the third rising edge.
- R3: In `ST_NORMAL`, a low middle flag moves the machine to `ST_PROTECT`. `wr_prot_o`=1 and `out_en_o`=0 in every state except `ST_NORMAL`. The middle flag returning high does not release protection.
- R4: In `ST_NORMAL`, while the top flag is low and the middle flag is high, `rst_pull_o`=1 and the memory stays writable (`wr_prot_o`=0). When the top flag returns, the reset request is released without any hold count.
- R5: In `ST_PROTECT`, a low lowest flag moves the machine to `ST_BATTERY`. This check takes priority over the top flag. `src_batt_o`=1 only in `ST_BATTERY`.
- R6: In `ST_BATTERY`, a high lowest flag returns the machine to `ST_PROTECT`, and `src_batt_o` returns to 0.
- R7: In `ST_PROTECT`, a high top flag moves the machine to `ST_HOLD`. In `ST_HOLD`, `wr_prot_o`=1 and `rst_pull_o`=1.
- R8: `ST_HOLD` lasts exactly `HOLD_CYCLES` clocks, then moves to `ST_NORMAL`. When a raise of all flags is driven from `ST_PROTECT`, `rst_pull_o` first reads 0 at the sample after `HOLD_CYCLES`+3 rising edges.
- R9: A low top flag during `ST_HOLD` returns the machine to `ST_PROTECT` and clears the count. The next recovery again waits the full `HOLD_CYCLES`.
- R10: `batt_armed_o` is 0 until the synchronized top flag is first seen high. From then on it stays 1 whatever the flags do, until `rst_n`.
- R11: `rst_pull_o`=1 whenever the state is not `ST_NORMAL`. The reset line is only pulled low or released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| lvl_trip_i | input | 1 | Supply above full-operation level (asynchronous) |
| lvl_wp_i | input | 1 | Supply above write-block level (asynchronous) |
| lvl_sw_i | input | 1 | Supply above backup switchover level (asynchronous) |
| wr_prot_o | output | 1 | 1 = memory inputs ignored, writes blocked |
| out_en_o | output | 1 | 1 = data output drivers allowed; 0 = forced high impedance |
| src_batt_o | output | 1 | 1 = memory fed from backup cell |
| batt_armed_o | output | 1 | Shipping seal broken, backup cell enabled (sticky) |
| rst_pull_o | output | 1 | 1 = pull the open-drain host reset line low |

## Verification
A wrong state shows up at once at the ports. A machine stuck in or wrongly leaving `ST_NORMAL` flips `wr_prot_o` and `out_en_o` on the clock edge after the mistake. A wrong move into or out of `ST_BATTERY` shows the same way on `src_batt_o`. A corrupted hold count has no effect at the ports until the release edge, which then comes early or late. For this reason the hold length is measured from the driven flag edge to the first release of `rst_pull_o`, both on a clean recovery and after an aborted one. A lost or spuriously set seal latch shows on `batt_armed_o` at the first sample after the top flag is synchronized.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;

    // Sequencer states; reset enters ST_PROTECT.
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_PROTECT = 2'd1,
        ST_BATTERY = 2'd2,
        ST_HOLD    = 2'd3
    } pwr_state_t;

    // Synchronized supply-level flags.
    typedef struct packed {
        logic trip;
        logic wp;
        logic sw;
    } lvl_t;

    localparam int LVL_W = $bits(lvl_t);

endpackage

// File: rtl/pwr_flag_sync.sv
`timescale 1ns/1ps
module pwr_flag_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0] chain [WIDTH];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[b] <= '0;
            end else begin
                chain[b] <= {chain[b][STAGES-2:0], async_i[b]};
            end
        end
        assign sync_o[b] = chain[b][STAGES-1];
    end

endmodule

// File: rtl/pwr_hold_timer.sv
`timescale 1ns/1ps
module pwr_hold_timer #(
    parameter int HOLD_CYCLES = 40_000_000
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               run_i,
    output logic                               done_o,
    output logic [$clog2(HOLD_CYCLES+1)-1:0]   cnt_o
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Count only while running; any pause clears the count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run_i) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done_o = run_i && (cnt == LAST);
    assign cnt_o  = cnt;

endmodule

// File: rtl/pwr_seal_latch.sv
`timescale 1ns/1ps
module pwr_seal_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic armed_o
);

    // Set once, never cleared except by controller reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_o <= 1'b0;
        end else if (arm_i) begin
            armed_o <= 1'b1;
        end
    end

endmodule

// File: rtl/pwr_seq_fsm.sv
`timescale 1ns/1ps
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lvl_t       lvl_i,
    input  logic       hold_done_i,
    output logic       hold_run_o,
    output pwr_state_t state_o,
    output logic       wr_prot_o,
    output logic       out_en_o,
    output logic       src_batt_o,
    output logic       rst_pull_o
);

    pwr_state_t state, nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PROTECT;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_NORMAL: begin
                if (!lvl_i.wp) nxt = ST_PROTECT;
            end
            ST_PROTECT: begin
                if (!lvl_i.sw)        nxt = ST_BATTERY;
                else if (lvl_i.trip)  nxt = ST_HOLD;
            end
            ST_BATTERY: begin
                if (lvl_i.sw) nxt = ST_PROTECT;
            end
            ST_HOLD: begin
                if (!lvl_i.trip)      nxt = ST_PROTECT;
                else if (hold_done_i) nxt = ST_NORMAL;
            end
            default: nxt = ST_PROTECT;
        endcase
    end

    // Outputs
    always_comb begin
        wr_prot_o  = 1'b1;
        out_en_o   = 1'b0;
        src_batt_o = 1'b0;
        rst_pull_o = 1'b1;
        hold_run_o = 1'b0;
        unique case (state)
            ST_NORMAL: begin
                wr_prot_o  = 1'b0;
                out_en_o   = 1'b1;
                rst_pull_o = !lvl_i.trip;
            end
            ST_PROTECT: ;
            ST_BATTERY: src_batt_o = 1'b1;
            ST_HOLD:    hold_run_o = 1'b1;
            default: ;
        endcase
    end

    assign state_o = state;

endmodule

// File: rtl/pwr_seq_top.sv
`timescale 1ns/1ps
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int HOLD_CYCLES = 40_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_trip_i,
    input  logic lvl_wp_i,
    input  logic lvl_sw_i,
    output logic wr_prot_o,
    output logic out_en_o,
    output logic src_batt_o,
    output logic batt_armed_o,
    output logic rst_pull_o
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);

    logic [LVL_W-1:0] raw_lvl, syn_lvl;
    lvl_t             lvl_s;
    logic             s_trip, s_wp, s_sw;
    logic             hold_run, hold_done;
    logic [CW-1:0]    hold_cnt;
    pwr_state_t       state;

    assign raw_lvl = {lvl_trip_i, lvl_wp_i, lvl_sw_i};

    pwr_flag_sync #(.WIDTH(LVL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_lvl),
        .sync_o (syn_lvl)
    );

    assign lvl_s  = lvl_t'(syn_lvl);
    assign s_trip = lvl_s.trip;
    assign s_wp   = lvl_s.wp;
    assign s_sw   = lvl_s.sw;

    pwr_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (lvl_s),
        .hold_done_i(hold_done),
        .hold_run_o (hold_run),
        .state_o    (state),
        .wr_prot_o  (wr_prot_o),
        .out_en_o   (out_en_o),
        .src_batt_o (src_batt_o),
        .rst_pull_o (rst_pull_o)
    );

    pwr_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (hold_run),
        .done_o(hold_done),
        .cnt_o (hold_cnt)
    );

    pwr_seal_latch u_seal (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (s_trip),
        .armed_o(batt_armed_o)
    );

endmodule

// File: rtl/pwr_seq_chk.sv
`timescale 1ns/1ps
module pwr_seq_chk #(
    parameter int HOLD_CYCLES = 40_000_000
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             s_trip,
    input logic                             s_wp,
    input logic                             s_sw,
    input logic [$clog2(HOLD_CYCLES+1)-1:0] hold_cnt,
    input logic                             wr_prot_o,
    input logic                             src_batt_o,
    input logic                             batt_armed_o,
    input logic                             rst_pull_o
);

    // R3
    wp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_prot_o && !s_wp) |=> wr_prot_o);

    // R5
    batt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_batt_o) |-> ($past(wr_prot_o) && !$past(s_sw)));

    // R6
    batt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_batt_o && s_sw) |=> !src_batt_o);

    // R9
    protect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prot_o && !s_trip) |=> wr_prot_o);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_prot_o) |-> $past(rst_pull_o));

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt < ($clog2(HOLD_CYCLES+1))'(HOLD_CYCLES));

    // R10
    armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(batt_armed_o) |-> batt_armed_o);

    // R11
    rst_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_prot_o |-> rst_pull_o);

endmodule

bind pwr_seq_top pwr_seq_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_trip      (s_trip),
    .s_wp        (s_wp),
    .s_sw        (s_sw),
    .hold_cnt    (hold_cnt),
    .wr_prot_o   (wr_prot_o),
    .src_batt_o  (src_batt_o),
    .batt_armed_o(batt_armed_o),
    .rst_pull_o  (rst_pull_o)
);

// File: tb/pwr_seq_top_tb.sv
`timescale 1ns/1ps
module pwr_seq_top_tb;

    localparam int HOLD = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ti = 1'b0, wi = 1'b0, si = 1'b0;
    logic wr_prot_o, out_en_o, src_batt_o, batt_armed_o, rst_pull_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    pwr_seq_top #(.HOLD_CYCLES(HOLD)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_trip_i  (ti),
        .lvl_wp_i    (wi),
        .lvl_sw_i    (si),
        .wr_prot_o   (wr_prot_o),
        .out_en_o    (out_en_o),
        .src_batt_o  (src_batt_o),
        .batt_armed_o(batt_armed_o),
        .rst_pull_o  (rst_pull_o)
    );

    // Behavioural reference: mode 0 normal, 1 protect, 2 battery, 3 hold.
    int m_mode = 1;
    int m_cnt  = 0;
    bit m_arm  = 0;
    bit dly_t[2] = '{0, 0};
    bit dly_w[2] = '{0, 0};
    bit dly_s[2] = '{0, 0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 1; m_cnt = 0; m_arm = 0;
            dly_t = '{0, 0}; dly_w = '{0, 0}; dly_s = '{0, 0};
        end else begin
            bit t, w, s;
            t = dly_t[1]; w = dly_w[1]; s = dly_s[1];
            case (m_mode)
                0: if (!w) m_mode = 1;
                1: begin
                    if (!s) m_mode = 2;
                    else if (t) begin m_mode = 3; m_cnt = 0; end
                end
                2: if (s) m_mode = 1;
                default: begin
                    if (!t) begin m_mode = 1; m_cnt = 0; end
                    else if (m_cnt == HOLD - 1) begin m_mode = 0; m_cnt = 0; end
                    else m_cnt++;
                end
            endcase
            if (t) m_arm = 1;
            dly_t[1] = dly_t[0]; dly_t[0] = ti;
            dly_w[1] = dly_w[0]; dly_w[0] = wi;
            dly_s[1] = dly_s[0]; dly_s[0] = si;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model on every cycle out of reset.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 wr_prot_o vs model", wr_prot_o, m_mode != 0);
            chk("R3 out_en_o vs model", out_en_o, m_mode == 0);
            chk("R5 src_batt_o vs model", src_batt_o, m_mode == 2);
            chk("R10 batt_armed_o vs model", batt_armed_o, m_arm);
            chk("R11 rst_pull_o vs model", rst_pull_o, (m_mode != 0) || !dly_t[1]);
        end
    end

    // Level 0..3 drives a monotone flag set.
    task automatic set_lvl(input int v);
        si = (v >= 1);
        wi = (v >= 2);
        ti = (v >= 3);
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic time_release(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (rst_pull_o && k < 400);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired (R8 sequence never completed)");
        finish_run();
    end

    initial begin
        int k;
        set_lvl(0);
        wait_n(3);
        // R1 reset values
        chk("R1 wr_prot_o", wr_prot_o, 1'b1);
        chk("R1 out_en_o", out_en_o, 1'b0);
        chk("R1 src_batt_o", src_batt_o, 1'b0);
        chk("R1 batt_armed_o", batt_armed_o, 1'b0);
        chk("R1 rst_pull_o", rst_pull_o, 1'b1);
        rst_n = 1'b1;
        wait_n(4);
        chk("R5 battery on empty supply", src_batt_o, 1'b1);

        // R2, R6: lowest flag returns
        set_lvl(1);
        wait_n(2);
        chk("R2 still battery after two edges", src_batt_o, 1'b1);
        wait_n(1);
        chk("R6 battery left on third edge", src_batt_o, 1'b0);
        chk("R10 seal closed before top level", batt_armed_o, 1'b0);

        set_lvl(2);
        wait_n(4);
        chk("R3 middle level alone keeps protect", wr_prot_o, 1'b1);

        // R7, R8 recovery
        set_lvl(3);
        wait_n(4);
        chk("R7 hold keeps protect", wr_prot_o, 1'b1);
        chk("R7 hold keeps reset", rst_pull_o, 1'b1);
        time_release(k);
        chk("R8 release edge count", k == HOLD + 3 - 4, 1'b1);
        chk("R8 normal after hold", out_en_o, 1'b1);
        chk("R10 seal broken", batt_armed_o, 1'b1);

        // R2, R4 warning in normal
        set_lvl(2);
        wait_n(1);
        chk("R2 reset not yet after one edge", rst_pull_o, 1'b0);
        wait_n(1);
        chk("R4 reset on top drop", rst_pull_o, 1'b1);
        wait_n(3);
        chk("R4 still writable", wr_prot_o, 1'b0);
        set_lvl(3);
        wait_n(2);
        chk("R4 reset released without hold", rst_pull_o, 1'b0);
        chk("R4 stays normal", out_en_o, 1'b1);

        // R3, R5 fall
        set_lvl(1);
        wait_n(4);
        chk("R3 protect on middle drop", wr_prot_o, 1'b1);
        chk("R3 drivers off", out_en_o, 1'b0);
        set_lvl(0);
        wait_n(4);
        chk("R5 battery select", src_batt_o, 1'b1);
        chk("R10 seal stays broken", batt_armed_o, 1'b1);

        // R9 abort
        set_lvl(3);
        wait_n(9);
        set_lvl(2);
        wait_n(5);
        chk("R9 abort to protect", wr_prot_o, 1'b1);
        chk("R9 abort keeps reset", rst_pull_o, 1'b1);
        set_lvl(3);
        time_release(k);
        chk("R9 full hold after abort", k == HOLD + 3, 1'b1);

        // Random monotone walk
        for (int seg = 0; seg < 150; seg++) begin
            set_lvl($urandom_range(0, 3));
            wait_n($urandom_range(1, 40));
        end

        finish_run();
    end

endmodule